// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Tag Controller

This block keeps the tag, valid and dirty state of a direct-mapped, non-sectored second-level cache that sits in front of main memory. A host access is presented as an address, a read/write flag and a flag that says whether the access targets main memory or I/O/peripheral space. The block replies with a registered decision: cacheable or not, hit or miss, whether a line fill is required and whether a dirty victim must first be written back. The data SRAM and the memory controller are outside the block. The block drives the writeback and fill requests and waits for their completion strobes.

The write policy is write-back without write allocation. A write hit marks its line dirty. A write miss goes straight to memory and leaves the array untouched. A size bit selects between a small and a large cache. The large cache has twice the lines and one more index bit. It keeps a tag word of the same width, in which the top bit serves as the valid flag and the remaining bits hold a tag one bit shorter. Only the low part of the main-memory address space is cacheable. Reset, a flush strobe or a change of the size bit clears the whole array, one index per clock.

Top module: `l2_tag_ctrl`

## Requirements
- R1: A line is 32 bytes. With the defaults in small mode, the line index is address bits [9:5] and the 8-bit tag is bits [17:10]. Two cacheable addresses with the same index and different tags evict each other.
- R2: A cacheable read whose line is resident reports rsp_hit=1, rsp_cacheable=1, rsp_fill=0 and rsp_wb=0.
- R3: A cacheable read miss reports rsp_fill=1. It raises fill_req with fill_addr equal to the requested address and holds it until fill_done. After that the same line hits.
- R4: When the victim of a read miss is valid and dirty, rsp_wb=1 and wb_req rises first, with wb_addr equal to the victim's line address. fill_req rises only in the cycle after wb_done, and wb_req and fill_req are never high together.
- R5: A write hit reports rsp_hit=1 and marks the line dirty. A write miss reports rsp_hit=0 and rsp_fill=0, and allocates nothing, so a later read of that line still misses.
- R6: An access is cacheable only when req_is_mem=1 and the address lies below 2^18 (the default cacheable limit). Any other access reports rsp_cacheable=0, rsp_hit=0, rsp_fill=0 and rsp_wb=0, and leaves the array unchanged.
- R7: In large mode (cfg_large=1) the index is bits [10:5] and the 7-bit tag is bits [17:11]. The top bit of the stored tag word is the valid flag. Addresses 0x40 and 0x440 can then be resident at the same time.
- R8: After reset or a flush strobe, busy is high and req_ready is low for at least 64 cycles (one per index of the large array). Afterwards every line misses, and dirty lines are dropped without a writeback.
- R9: cfg_large is acted on only while the controller is idle. A change made during a pending fill does not raise busy until the fill completes. The change then invalidates the whole array.
- R10: rsp_valid pulses in the second cycle after the accept edge. A new request can be accepted on the same edge that registers the previous decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_large | input | 1 | Cache size select: 0 small, 1 large |
| flush | input | 1 | Strobe that invalidates the whole array |
| req_valid | input | 1 | Host access present |
| req_ready | output | 1 | Access accepted on this edge when req_valid is high |
| req_write | input | 1 | 1 write, 0 read |
| req_is_mem | input | 1 | 1 main memory, 0 I/O or peripheral space |
| req_addr | input | 32 | Byte address |
| rsp_valid | output | 1 | Decision valid (one-cycle pulse) |
| rsp_hit | output | 1 | Line resident |
| rsp_cacheable | output | 1 | Access falls in the cacheable range |
| rsp_fill | output | 1 | Line fill will be requested |
| rsp_wb | output | 1 | Dirty victim writeback will be requested |
| wb_req | output | 1 | Victim writeback request |
| wb_addr | output | 32 | Victim line address |
| wb_done | input | 1 | Writeback completed |
| fill_req | output | 1 | Line fill request |
| fill_addr | output | 32 | Requested address of the missing line |
| fill_done | input | 1 | Fill completed |
| busy | output | 1 | Invalidation walk in progress |

## Verification
The interaction to watch is a write hit that marks a line dirty on the same edge that accepts the next request, when that next request is a read to the same index with a different tag. The bench provokes this by issuing the write and the conflicting read back to back. It judges the outcome by the read's decision: it must report both a fill and a writeback, and wb_addr must name the line that was just written. A second overlap is a size change made while a fill is pending. The bench judges this by busy staying low until fill_done, then rising, after which a previously resident line misses.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2,
    ST_WALK = 2'd3
  } tc_state_e;
endpackage

// File: rtl/tc_lookup.sv
// Splits a line address into index and tag for the active size mode and
// compares it against the stored tag word.
module tc_lookup #(
  parameter int LN_W  = 27,
  parameter int IDX_S = 5,
  parameter int C_LN  = 13
) (
  input  logic                  cfg_large,
  input  logic [LN_W-1:0]       line,
  input  logic                  is_mem,
  input  logic [C_LN-IDX_S-1:0] word,
  input  logic                  vbit,
  output logic [IDX_S:0]        idx,
  output logic [C_LN-IDX_S-1:0] new_word,
  output logic                  hit,
  output logic                  cacheable,
  output logic                  victim_valid,
  output logic [LN_W-1:0]       victim_line
);
  localparam int IDX_L = IDX_S + 1;
  localparam int TAG_W = C_LN - IDX_S;

  logic [IDX_S-1:0] idx_s;
  logic [IDX_L-1:0] idx_l;
  logic [TAG_W-1:0] tag_s;
  logic [TAG_W-2:0] tag_l;

  assign idx_s = line[IDX_S-1:0];
  assign idx_l = line[IDX_L-1:0];
  assign tag_s = line[IDX_S +: TAG_W];
  assign tag_l = line[IDX_L +: TAG_W-1];

  assign cacheable    = is_mem && (line[LN_W-1:C_LN] == '0);
  assign idx          = cfg_large ? idx_l : {1'b0, idx_s};
  assign new_word     = cfg_large ? {1'b1, tag_l} : tag_s;
  assign victim_valid = cfg_large ? word[TAG_W-1] : vbit;
  assign hit          = cacheable && victim_valid && (word == new_word);

  always_comb begin
    victim_line = '0;
    if (cfg_large) begin
      victim_line[IDX_L-1:0]       = idx_l;
      victim_line[IDX_L +: TAG_W-1] = word[TAG_W-2:0];
    end else begin
      victim_line[IDX_S-1:0]       = idx_s;
      victim_line[IDX_S +: TAG_W]  = word;
    end
  end
endmodule

// File: rtl/tc_tag_store.sv
// Tag word array plus per-line valid and dirty bits. Cleared by the walk.
module tc_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_word,
  output logic             rd_vbit,
  output logic             rd_dirty,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_word,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] word_mem [DEPTH];
  logic [DEPTH-1:0] vbit_q;
  logic [DEPTH-1:0] dirty_q;

  assign rd_word  = word_mem[rd_idx];
  assign rd_vbit  = vbit_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

  always_ff @(posedge clk) begin
    if (clr_en) begin
      word_mem[clr_idx] <= '0;
      vbit_q[clr_idx]   <= 1'b0;
      dirty_q[clr_idx]  <= 1'b0;
    end else begin
      if (fill_en) begin
        word_mem[fill_idx] <= fill_word;
        vbit_q[fill_idx]   <= 1'b1;
        dirty_q[fill_idx]  <= 1'b0;
      end
      if (dirty_en) begin
        dirty_q[dirty_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tc_ctrl.sv
// Sequencer: idle, writeback, fill and invalidation walk.
module tc_ctrl
  import tc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             s1_v,
  input  logic             miss_go,
  input  logic             victim_dirty,
  input  logic             flush,
  input  logic             cfg_large,
  input  logic             wb_done,
  input  logic             fill_done,
  output tc_state_e        st,
  output logic             cfg_q,
  output logic [IDX_W-1:0] walk_idx,
  output logic             walk_en,
  output logic             fill_en,
  output logic             ready,
  output logic             busy
);
  tc_state_e        st_nx;
  logic             cfg_nx;
  logic             pend_q, pend_nx;
  logic [IDX_W-1:0] cnt_nx;
  logic             cfg_diff, walk_go, walk_last;

  assign cfg_diff  = cfg_large != cfg_q;
  assign walk_go   = (st == ST_IDLE) && !s1_v && (pend_q || flush || cfg_diff);
  assign walk_last = walk_idx == '1;
  assign walk_en   = st == ST_WALK;
  assign fill_en   = (st == ST_FILL) && fill_done;
  assign ready     = (st == ST_IDLE) && !pend_q && !cfg_diff;
  assign busy      = st == ST_WALK;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: begin
        if (walk_go)              st_nx = ST_WALK;
        else if (s1_v && miss_go) st_nx = victim_dirty ? ST_WB : ST_FILL;
      end
      ST_WB:   if (wb_done)   st_nx = ST_FILL;
      ST_FILL: if (fill_done) st_nx = ST_IDLE;
      ST_WALK: if (walk_last) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_nx = (pend_q || flush) && !walk_go;
    cfg_nx  = walk_en ? cfg_large : cfg_q;
    cnt_nx  = walk_en ? walk_idx + 1'b1 : walk_idx;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_WALK;
      pend_q   <= 1'b0;
      cfg_q    <= 1'b0;
      walk_idx <= '0;
    end else begin
      st       <= st_nx;
      pend_q   <= pend_nx;
      cfg_q    <= cfg_nx;
      walk_idx <= cnt_nx;
    end
  end
endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl
  import tc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 5,
  parameter int IDX_S   = 5,
  parameter int CACHE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_large,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_is_mem,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_cacheable,
  output logic              rsp_fill,
  output logic              rsp_wb,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_done,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_done,
  output logic              busy
);
  localparam int IDX_L = IDX_S + 1;
  localparam int LN_W  = ADDR_W - OFF_W;
  localparam int C_LN  = CACHE_W - OFF_W;
  localparam int TAG_W = C_LN - IDX_S;

  // reset: asynchronous assert, synchronous release
  logic rst_q1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_ni, rst_q1} <= 2'b00;
    else        {rst_ni, rst_q1} <= {rst_q1, 1'b1};
  end

  tc_state_e        st;
  logic             cfg_q, walk_en, fill_en, ready;
  logic [IDX_L-1:0] walk_idx;

  // stage 1: accepted address
  logic              s1_v, s1_v_nx, s1_wr, s1_wr_nx, s1_mem, s1_mem_nx;
  logic [ADDR_W-1:0] s1_addr, s1_addr_nx;
  logic              accept, decide;

  assign accept    = req_valid && ready;
  assign decide    = (st == ST_IDLE) && s1_v;
  assign req_ready = ready;

  always_comb begin
    s1_v_nx    = accept ? 1'b1 : (decide ? 1'b0 : s1_v);
    s1_wr_nx   = accept ? req_write  : s1_wr;
    s1_mem_nx  = accept ? req_is_mem : s1_mem;
    s1_addr_nx = accept ? req_addr   : s1_addr;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_mem <= 1'b0; s1_addr <= '0;
    end else begin
      s1_v <= s1_v_nx; s1_wr <= s1_wr_nx; s1_mem <= s1_mem_nx; s1_addr <= s1_addr_nx;
    end
  end

  // lookup against the array
  logic [TAG_W-1:0] rd_word, lk_word;
  logic             rd_vbit, rd_dirty;
  logic [IDX_L-1:0] lk_idx;
  logic             lk_hit, lk_cacheable, lk_vvalid;
  logic [LN_W-1:0]  lk_vline;
  logic             miss_go, victim_dirty, dirty_en;

  tc_lookup #(.LN_W(LN_W), .IDX_S(IDX_S), .C_LN(C_LN)) u_lookup (
    .cfg_large   (cfg_q),
    .line        (s1_addr[ADDR_W-1:OFF_W]),
    .is_mem      (s1_mem),
    .word        (rd_word),
    .vbit        (rd_vbit),
    .idx         (lk_idx),
    .new_word    (lk_word),
    .hit         (lk_hit),
    .cacheable   (lk_cacheable),
    .victim_valid(lk_vvalid),
    .victim_line (lk_vline)
  );

  assign miss_go      = lk_cacheable && !s1_wr && !lk_hit;
  assign victim_dirty = lk_vvalid && rd_dirty;
  assign dirty_en     = decide && s1_wr && lk_hit;

  // miss context
  logic [IDX_L-1:0]  m_idx, m_idx_nx;
  logic [TAG_W-1:0]  m_word, m_word_nx;
  logic [ADDR_W-1:0] m_addr, m_addr_nx, v_addr, v_addr_nx;
  logic              m_load;

  assign m_load = decide && miss_go;

  always_comb begin
    m_idx_nx  = m_load ? lk_idx  : m_idx;
    m_word_nx = m_load ? lk_word : m_word;
    m_addr_nx = m_load ? s1_addr : m_addr;
    v_addr_nx = m_load ? {lk_vline, {OFF_W{1'b0}}} : v_addr;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_idx <= '0; m_word <= '0; m_addr <= '0; v_addr <= '0;
    end else begin
      m_idx <= m_idx_nx; m_word <= m_word_nx; m_addr <= m_addr_nx; v_addr <= v_addr_nx;
    end
  end

  tc_tag_store #(.IDX_W(IDX_L), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rd_idx   (lk_idx),
    .rd_word  (rd_word),
    .rd_vbit  (rd_vbit),
    .rd_dirty (rd_dirty),
    .clr_en   (walk_en),
    .clr_idx  (walk_idx),
    .fill_en  (fill_en),
    .fill_idx (m_idx),
    .fill_word(m_word),
    .dirty_en (dirty_en),
    .dirty_idx(lk_idx)
  );

  tc_ctrl #(.IDX_W(IDX_L)) u_ctrl (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .s1_v        (s1_v),
    .miss_go     (miss_go),
    .victim_dirty(victim_dirty),
    .flush       (flush),
    .cfg_large   (cfg_large),
    .wb_done     (wb_done),
    .fill_done   (fill_done),
    .st          (st),
    .cfg_q       (cfg_q),
    .walk_idx    (walk_idx),
    .walk_en     (walk_en),
    .fill_en     (fill_en),
    .ready       (ready),
    .busy        (busy)
  );

  // registered decision
  logic rv_nx, rh_nx, rc_nx, rf_nx, rw_nx;
  always_comb begin
    rv_nx = decide;
    rh_nx = decide ? lk_hit                  : rsp_hit;
    rc_nx = decide ? lk_cacheable            : rsp_cacheable;
    rf_nx = decide ? miss_go                 : rsp_fill;
    rw_nx = decide ? (miss_go && victim_dirty) : rsp_wb;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_cacheable <= 1'b0;
      rsp_fill  <= 1'b0; rsp_wb  <= 1'b0;
    end else begin
      rsp_valid <= rv_nx; rsp_hit <= rh_nx; rsp_cacheable <= rc_nx;
      rsp_fill  <= rf_nx; rsp_wb  <= rw_nx;
    end
  end

  assign wb_req    = st == ST_WB;
  assign wb_addr   = v_addr;
  assign fill_req  = st == ST_FILL;
  assign fill_addr = m_addr;
endmodule

// File: rtl/l2_tag_ctrl_chk.sv
module l2_tag_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic busy,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_cacheable,
  input logic rsp_fill,
  input logic rsp_wb,
  input logic wb_req,
  input logic wb_done,
  input logic fill_req,
  input logic fill_done,
  input logic s1_v,
  input logic s1_wr
);
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_done |=> fill_req); // R4
  AST_WB_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_req && fill_req)); // R4
  AST_WB_IMPLIES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wb |-> rsp_fill); // R4
  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_done |=> fill_req); // R3
  AST_NO_WRITE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fill |-> !$past(s1_wr)); // R5
  AST_UNCACHED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_cacheable |-> !rsp_hit && !rsp_fill && !rsp_wb); // R6
  AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R8
  AST_RSP_FROM_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(s1_v)); // R10
endmodule

bind l2_tag_ctrl l2_tag_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .busy         (busy),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_cacheable(rsp_cacheable),
  .rsp_fill     (rsp_fill),
  .rsp_wb       (rsp_wb),
  .wb_req       (wb_req),
  .wb_done      (wb_done),
  .fill_req     (fill_req),
  .fill_done    (fill_done),
  .s1_v         (s1_v),
  .s1_wr        (s1_wr)
);

// File: tb/l2_tag_ctrl_bench.sv
module l2_tag_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_large = 1'b0, flush = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_is_mem = 1'b0;
  logic [31:0] req_addr = '0;
  logic        wb_done = 1'b0, fill_done = 1'b0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_cacheable, rsp_fill, rsp_wb;
  logic        wb_req, fill_req, busy;
  logic [31:0] wb_addr, fill_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  l2_tag_ctrl u_l2_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_large(cfg_large), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_is_mem(req_is_mem), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cacheable(rsp_cacheable),
    .rsp_fill(rsp_fill), .rsp_wb(rsp_wb),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_done(wb_done),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_done(fill_done),
    .busy(busy)
  );

  // exp = {hit, cacheable, fill, wb}
  typedef struct packed {
    logic        wr;
    logic        mem;
    logic [31:0] addr;
    logic [3:0]  exp;
    logic [31:0] vaddr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 32'h0000_0040, 4'b0110, 32'h0},          // cold read miss
    '{1'b0, 1'b1, 32'h0000_0040, 4'b1100, 32'h0},          // read hit
    '{1'b1, 1'b1, 32'h0000_0040, 4'b1100, 32'h0},          // write hit, dirty
    '{1'b0, 1'b1, 32'h0000_0440, 4'b0111, 32'h0000_0040},  // conflict, dirty victim
    '{1'b0, 1'b1, 32'h0000_0440, 4'b1100, 32'h0},
    '{1'b1, 1'b1, 32'h0000_0860, 4'b0100, 32'h0},          // write miss
    '{1'b0, 1'b1, 32'h0000_0860, 4'b0110, 32'h0},          // not allocated
    '{1'b0, 1'b0, 32'h0000_0440, 4'b0000, 32'h0},          // I/O space
    '{1'b0, 1'b1, 32'h0004_0440, 4'b0000, 32'h0},          // above limit
    '{1'b0, 1'b1, 32'h0000_0440, 4'b1100, 32'h0},          // still resident
    '{1'b0, 1'b1, 32'h0003_FC40, 4'b0110, 32'h0},          // top tag, clean victim
    '{1'b0, 1'b1, 32'h0003_FC40, 4'b1100, 32'h0}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R3";
      1, 4, 11: return "R2";
      2, 5, 6: return "R5";
      3: return "R1/R4";
      7, 8, 9: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic wr, input logic mem, input logic [31:0] a);
    @(negedge clk);
    req_write = wr; req_is_mem = mem; req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic get_rsp(input logic [3:0] exp, input string rq);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R10", {31'b0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R10", {31'b0, rsp_valid}, 32'd1);
    chk({rsp_hit, rsp_cacheable, rsp_fill, rsp_wb} == exp, rq,
        {28'b0, rsp_hit, rsp_cacheable, rsp_fill, rsp_wb}, {28'b0, exp});
  endtask

  // entered at the negedge where the decision is visible
  task automatic service(input logic wb, input logic [31:0] vaddr, input logic [31:0] a);
    if (wb) begin
      chk(wb_req && !fill_req, "R4", {30'b0, wb_req, fill_req}, 32'h2);
      chk(wb_addr == vaddr, "R4", wb_addr, vaddr);
      @(negedge clk);
      chk(!fill_req, "R4", {31'b0, fill_req}, 32'd0);
      wb_done = 1'b1;
      @(negedge clk);
      wb_done = 1'b0;
    end
    chk(fill_req && !wb_req, "R3", {30'b0, fill_req, wb_req}, 32'h2);
    chk(fill_addr == a, "R3", fill_addr, a);
    fill_done = 1'b1;
    @(negedge clk);
    fill_done = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [3:0] exp,
                        input logic [31:0] vaddr, input string rq);
    send(wr, 1'b1, a);
    get_rsp(exp, rq);
    if (exp[1]) service(exp[0], vaddr, a);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int walk_cycles;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(busy && !req_ready && !rsp_valid, "R8", {29'b0, busy, req_ready, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    walk_cycles = 0;
    @(negedge clk);
    while (busy) begin walk_cycles++; @(negedge clk); end
    chk(walk_cycles >= 64, "R8", walk_cycles, 32'd64);

    // table walk, small mode
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].wr, VECS[i].mem, VECS[i].addr);
      get_rsp(VECS[i].exp, vtag(i));
      if (VECS[i].exp[1]) service(VECS[i].exp[0], VECS[i].vaddr, VECS[i].addr);
      else chk(!fill_req && !wb_req, vtag(i), {30'b0, fill_req, wb_req}, 32'd0);
    end

    // R10/R5: write hit and conflicting read back to back
    send(1'b1, 1'b1, 32'h0003_FC40);
    @(negedge clk);
    chk(req_ready, "R10", {31'b0, req_ready}, 32'd1);
    req_write = 1'b0; req_addr = 32'h0000_0040;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && {rsp_hit, rsp_cacheable, rsp_fill, rsp_wb} == 4'b1100, "R5",
        {27'b0, rsp_valid, rsp_hit, rsp_cacheable, rsp_fill, rsp_wb}, 32'h1C);
    @(negedge clk);
    chk(rsp_valid && {rsp_hit, rsp_cacheable, rsp_fill, rsp_wb} == 4'b0111, "R10",
        {27'b0, rsp_valid, rsp_hit, rsp_cacheable, rsp_fill, rsp_wb}, 32'h17);
    service(1'b1, 32'h0003_FC40, 32'h0000_0040);

    // R8: flush drops a dirty line
    access(1'b1, 32'h0000_0040, 4'b1100, 32'h0, "R5");
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(busy && !req_ready, "R8", {30'b0, busy, req_ready}, 32'h2);
    wait_idle();
    access(1'b0, 32'h0000_0040, 4'b0110, 32'h0, "R8");

    // R7: large mode, lines that conflict in small mode coexist
    @(negedge clk);
    cfg_large = 1'b1;
    @(negedge clk);
    chk(busy, "R9", {31'b0, busy}, 32'd1);
    wait_idle();
    access(1'b0, 32'h0000_0040, 4'b0110, 32'h0, "R9");
    access(1'b0, 32'h0000_0440, 4'b0110, 32'h0, "R7");
    access(1'b0, 32'h0000_0040, 4'b1100, 32'h0, "R7");
    access(1'b0, 32'h0000_0840, 4'b0110, 32'h0, "R7");
    access(1'b0, 32'h0000_0440, 4'b1100, 32'h0, "R7");

    // R9: size change during a pending fill waits for idle
    send(1'b0, 1'b1, 32'h0000_0040);
    get_rsp(4'b0110, "R7");
    cfg_large = 1'b0;
    @(negedge clk);
    chk(!busy && fill_req, "R9", {30'b0, busy, fill_req}, 32'h1);
    service(1'b0, 32'h0, 32'h0000_0040);
    @(negedge clk);
    chk(busy, "R9", {31'b0, busy}, 32'd1);
    wait_idle();
    access(1'b0, 32'h0000_0440, 4'b0110, 32'h0, "R9");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule